// File: doc/BRIEF.md
# Clock-Line Timeout Power Mode Controller

This block decides the power mode of a coil actuator driver. It watches the
serial clock line, which reaches it as an already synchronised "line is low"
level. It also watches the committed 10-bit coil current code, a software reset
strobe, and three fault flags: over-temperature, coil short and coil open. If
the clock line is held low for 0.5 ms, the driver powers down. When the line
returns high, the driver wakes into an idle state and the register defaults
are loaded. A nonzero current code takes the driver into the running state,
where the output stage is enabled.

The state machine has three states. SHUTDOWN (code 0) is the lowest power
state. STANDBY (code 1) has the output stage off and the registers writable.
ACTIVE (code 2) has the output stage on. The named transitions are:

- TIMEOUT: any state to SHUTDOWN.
- WAKE: SHUTDOWN to STANDBY, with a defaults load.
- START: STANDBY to ACTIVE, with a status clear.
- IDLE: ACTIVE to STANDBY on a zero code.
- SOFT_RESET: STANDBY or ACTIVE to STANDBY, with a defaults load.
- FAULT_STOP: ACTIVE to STANDBY, with a current register clear.

The timeout length in clock cycles is derived from the `CLK_HZ` and `HOLD_US` parameters.

Top module: `actuator_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, `mode` is SHUTDOWN (2'd0) and `stage_en`, `load_dflt`, `cur_clr` and `stat_clr` are all 0. The mode codes are SHUTDOWN=0, STANDBY=1 and ACTIVE=2.
- R2: (TIMEOUT) Let LIMIT = CLK_HZ/1000*HOLD_US/1000. When `scl_low` has been 1 for LIMIT consecutive clock samples, `mode` is SHUTDOWN after the LIMIT-th sampling edge, whatever the previous mode. `mode` stays SHUTDOWN while `scl_low` remains 1. A low run shorter than LIMIT samples does not change the mode.
- R3: (WAKE) In SHUTDOWN, one sample with `scl_low`=0 moves `mode` to STANDBY after that edge. `load_dflt` is 1 for exactly that one cycle.
- R4: (START) In STANDBY, a nonzero `cur_code` with `flt_ot`=0 and no `sw_rst` moves `mode` to ACTIVE after one edge. `stat_clr` is 1 for exactly that one cycle.
- R5: (IDLE) In ACTIVE, a zero `cur_code` with no fault and no `sw_rst` returns `mode` to STANDBY. No pulse output is raised.
- R6: (SOFT_RESET) `sw_rst`=1 in STANDBY or ACTIVE gives `mode`=STANDBY with a one-cycle `load_dflt`. This takes priority over faults and over the current code. A timeout takes priority over `sw_rst`. `sw_rst` has no effect in SHUTDOWN.
- R7: (FAULT_STOP) In ACTIVE, `flt_ot`, `flt_short` or `flt_open` at 1 (without `sw_rst`) gives `mode`=STANDBY with a one-cycle `cur_clr`.
- R8: While `flt_ot` is 1, `mode` does not move from STANDBY to ACTIVE, even with a nonzero `cur_code`.
- R9: `stage_en` is 1 exactly when `mode` is ACTIVE. At most one of `load_dflt`, `cur_clr` and `stat_clr` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_low | input | 1 | Synchronised indication that the serial clock line is low |
| cur_code | input | 10 | Committed coil current code |
| sw_rst | input | 1 | Software reset strobe |
| flt_ot | input | 1 | Over-temperature fault flag |
| flt_short | input | 1 | Coil short fault flag |
| flt_open | input | 1 | Coil open fault flag |
| mode | output | 2 | Current mode: 0 SHUTDOWN, 1 STANDBY, 2 ACTIVE |
| stage_en | output | 1 | Output stage enable |
| load_dflt | output | 1 | One-cycle pulse to load register defaults |
| cur_clr | output | 1 | One-cycle pulse to clear the current register |
| stat_clr | output | 1 | One-cycle pulse to clear the status bits |

## Verification
The assertions assume that `scl_low` is already synchronised to `clk` and is sampled once per edge. They also assume that `cur_code` reflects the register contents, so the code is not cleared by this block within the same cycle as a `cur_clr` pulse. The stimulus holds the current code for several cycles at a time and mixes short glitches with long low runs on `scl_low`. Some runs stop just short of LIMIT and some go well beyond it. The timeout parameters are scaled down so that many full timeouts fit in one run.

// File: rtl/actuator_mode_pkg.sv
package actuator_mode_pkg;

    typedef enum logic [1:0] {
        MODE_SHUTDOWN = 2'd0,
        MODE_STANDBY  = 2'd1,
        MODE_ACTIVE   = 2'd2
    } pwr_mode_e;

endpackage

// File: rtl/scl_low_timer.sv
module scl_low_timer #(
    parameter int LIMIT_CYC = 62500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_low,
    output logic expired
);
    localparam int CNT_W = (LIMIT_CYC > 2) ? $clog2(LIMIT_CYC) : 1;
    localparam logic [CNT_W-1:0] TOP = CNT_W'(LIMIT_CYC - 1);

    // counts earlier consecutive low samples, saturating at LIMIT-1
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!scl_low) begin
            cnt_q <= '0;
        end else if (cnt_q != TOP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // this sample is the LIMIT-th consecutive low one
    assign expired = scl_low && (cnt_q == TOP);

endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
    import actuator_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      scl_low,
    input  logic      timeout,
    input  logic      cur_nz,
    input  logic      sw_rst,
    input  logic      flt_ot,
    input  logic      flt_any,
    output pwr_mode_e state_q,
    output logic      stage_en,
    output logic      load_dflt,
    output logic      cur_clr,
    output logic      stat_clr
);
    pwr_mode_e nxt;
    logic      ld_nxt, cc_nxt, sc_nxt;

    always_comb begin
        nxt    = state_q;
        ld_nxt = 1'b0;
        cc_nxt = 1'b0;
        sc_nxt = 1'b0;
        if (timeout) begin
            nxt = MODE_SHUTDOWN;                 // TIMEOUT
        end else begin
            unique case (state_q)
                MODE_SHUTDOWN: begin
                    if (!scl_low) begin
                        nxt    = MODE_STANDBY;   // WAKE
                        ld_nxt = 1'b1;
                    end
                end
                MODE_STANDBY: begin
                    if (sw_rst) begin
                        ld_nxt = 1'b1;           // SOFT_RESET
                    end else if (cur_nz && !flt_ot) begin
                        nxt    = MODE_ACTIVE;    // START
                        sc_nxt = 1'b1;
                    end
                end
                MODE_ACTIVE: begin
                    if (sw_rst) begin
                        nxt    = MODE_STANDBY;   // SOFT_RESET
                        ld_nxt = 1'b1;
                    end else if (flt_any) begin
                        nxt    = MODE_STANDBY;   // FAULT_STOP
                        cc_nxt = 1'b1;
                    end else if (!cur_nz) begin
                        nxt    = MODE_STANDBY;   // IDLE
                    end
                end
                default: begin
                    nxt = MODE_SHUTDOWN;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_SHUTDOWN;
        end else begin
            state_q <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_en  <= 1'b0;
            load_dflt <= 1'b0;
            cur_clr   <= 1'b0;
            stat_clr  <= 1'b0;
        end else begin
            stage_en  <= (nxt == MODE_ACTIVE);
            load_dflt <= ld_nxt;
            cur_clr   <= cc_nxt;
            stat_clr  <= sc_nxt;
        end
    end

endmodule

// File: rtl/actuator_mode_ctrl.sv
module actuator_mode_ctrl
    import actuator_mode_pkg::*;
#(
    parameter int CLK_HZ  = 125_000_000,
    parameter int HOLD_US = 500,
    parameter int CODE_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_low,
    input  logic [CODE_W-1:0] cur_code,
    input  logic              sw_rst,
    input  logic              flt_ot,
    input  logic              flt_short,
    input  logic              flt_open,
    output logic [1:0]        mode,
    output logic              stage_en,
    output logic              load_dflt,
    output logic              cur_clr,
    output logic              stat_clr
);
    localparam int LIMIT_CYC = (CLK_HZ / 1000) * HOLD_US / 1000;

    logic      timeout;
    pwr_mode_e state;

    scl_low_timer #(
        .LIMIT_CYC (LIMIT_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_low (scl_low),
        .expired (timeout)
    );

    mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_low   (scl_low),
        .timeout   (timeout),
        .cur_nz    (|cur_code),
        .sw_rst    (sw_rst),
        .flt_ot    (flt_ot),
        .flt_any   (flt_ot | flt_short | flt_open),
        .state_q   (state),
        .stage_en  (stage_en),
        .load_dflt (load_dflt),
        .cur_clr   (cur_clr),
        .stat_clr  (stat_clr)
    );

    assign mode = state;

endmodule

// File: rtl/mode_ctrl_checker.sv
module mode_ctrl_checker #(
    parameter int LIMIT_CYC = 62500,
    parameter int CODE_W    = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_low,
    input logic [CODE_W-1:0] cur_code,
    input logic              sw_rst,
    input logic              flt_ot,
    input logic              flt_short,
    input logic              flt_open,
    input logic [1:0]        mode,
    input logic              stage_en,
    input logic              load_dflt,
    input logic              cur_clr,
    input logic              stat_clr
);
    localparam int LW = $clog2(LIMIT_CYC + 1);
    localparam logic [LW-1:0] LIM = LW'(LIMIT_CYC);

    logic [LW-1:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (!scl_low) begin
            low_run <= '0;
        end else if (low_run != LIM) begin
            low_run <= low_run + 1'b1;
        end
    end

    p_timeout_shutdown_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (low_run == LIM) |-> (mode == 2'd0));

    p_wake_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && !scl_low) |=> (mode == 2'd1 && load_dflt));

    p_start_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr |-> (mode == 2'd2 && $past(mode) == 2'd1));

    p_idle_on_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && cur_code == '0) |=> (mode != 2'd2));

    p_softrst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd0 && sw_rst && !(scl_low && low_run == LIM - 1'b1))
        |=> (mode == 2'd1 && load_dflt));

    p_fault_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && (flt_ot || flt_short || flt_open)) |=> (mode != 2'd2));

    p_ot_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && flt_ot) |=> (mode != 2'd2));

    p_stage_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stage_en == (mode == 2'd2));

    p_pulse_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_dflt, cur_clr, stat_clr}));

endmodule

bind actuator_mode_ctrl mode_ctrl_checker #(
    .LIMIT_CYC (LIMIT_CYC),
    .CODE_W    (CODE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_low   (scl_low),
    .cur_code  (cur_code),
    .sw_rst    (sw_rst),
    .flt_ot    (flt_ot),
    .flt_short (flt_short),
    .flt_open  (flt_open),
    .mode      (mode),
    .stage_en  (stage_en),
    .load_dflt (load_dflt),
    .cur_clr   (cur_clr),
    .stat_clr  (stat_clr)
);

// File: tb/actuator_mode_ctrl_bench.sv
module actuator_mode_ctrl_bench;
    localparam int CLK_HZ = 200_000;      // scaled timeout: 100 cycles
    localparam int LIMIT  = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_low = 1'b1;
    logic [9:0] cur_code = '0;
    logic       sw_rst = 1'b0, flt_ot = 1'b0, flt_short = 1'b0, flt_open = 1'b0;
    logic [1:0] mode;
    logic       stage_en, load_dflt, cur_clr, stat_clr;

    int nchk = 0;
    int nbad = 0;
    bit done = 0;

    // bench model state
    int         m_low = 0;
    logic [1:0] m_mode = 2'd0;
    logic       m_en = 0, m_ld = 0, m_cc = 0, m_sc = 0;
    string      m_tag = "R1";

    always #4 clk = ~clk;

    actuator_mode_ctrl #(.CLK_HZ(CLK_HZ), .HOLD_US(500), .CODE_W(10)) u_actuator_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .scl_low(scl_low), .cur_code(cur_code),
        .sw_rst(sw_rst), .flt_ot(flt_ot), .flt_short(flt_short), .flt_open(flt_open),
        .mode(mode), .stage_en(stage_en), .load_dflt(load_dflt),
        .cur_clr(cur_clr), .stat_clr(stat_clr)
    );

    task automatic check(string tag, logic [5:0] act, logic [5:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%b expected=%b (mode,en,ld,cc,sc)", tag, act, exp);
        end
    endtask

    // expected outputs after one edge, built from the requirements
    task automatic model_step();
        logic [1:0] nm;
        m_low = scl_low ? ((m_low < LIMIT) ? m_low + 1 : LIMIT) : 0;
        nm = m_mode; m_ld = 0; m_cc = 0; m_sc = 0;
        if (m_low >= LIMIT) begin
            nm = 2'd0; m_tag = "R2";
        end else begin
            case (m_mode)
                2'd0: begin
                    m_tag = "R6";
                    if (!scl_low) begin nm = 2'd1; m_ld = 1; m_tag = "R3"; end
                end
                2'd1: begin
                    m_tag = "R8";
                    if (sw_rst) begin m_ld = 1; m_tag = "R6"; end
                    else if (cur_code != 0 && !flt_ot) begin nm = 2'd2; m_sc = 1; m_tag = "R4"; end
                end
                default: begin
                    m_tag = "R9";
                    if (sw_rst) begin nm = 2'd1; m_ld = 1; m_tag = "R6"; end
                    else if (flt_ot | flt_short | flt_open) begin nm = 2'd1; m_cc = 1; m_tag = "R7"; end
                    else if (cur_code == 0) begin nm = 2'd1; m_tag = "R5"; end
                end
            endcase
        end
        m_mode = nm;
        m_en = (nm == 2'd2);
    endtask

    // called at a falling edge: drive, advance one clock, compare
    task automatic cyc(logic s, logic [9:0] c, logic r, logic ot, logic sh, logic op);
        scl_low = s; cur_code = c; sw_rst = r; flt_ot = ot; flt_short = sh; flt_open = op;
        model_step();
        @(posedge clk);
        @(negedge clk);
        check(m_tag, {mode, stage_en, load_dflt, cur_clr, stat_clr},
              {m_mode, m_en, m_ld, m_cc, m_sc});
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            nbad++; nchk++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        int low_left;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1", {mode, stage_en, load_dflt, cur_clr, stat_clr}, 6'b00_0000);
        rst_n = 1'b1;

        cyc(0, 0, 0, 0, 0, 0);                       // R3 wake
        check("R3", {mode, load_dflt}, {2'd1, 1'b1});
        cyc(0, 0, 0, 0, 0, 0);                       // pulse gone
        check("R3", {5'b0, load_dflt}, 6'b0);
        cyc(0, 0, 1, 0, 0, 0);                       // R6 soft reset in standby
        cyc(0, 10'd5, 0, 0, 0, 0);                   // R4 start
        check("R4", {mode, stage_en, stat_clr}, {2'd2, 1'b1, 1'b1});
        cyc(0, 10'd5, 1, 1, 0, 0);                   // R6 beats fault
        check("R6", {mode, load_dflt, cur_clr}, {2'd1, 1'b1, 1'b0});
        cyc(0, 10'd5, 0, 0, 0, 0);
        cyc(0, 10'd5, 0, 0, 1, 0);                   // R7 short
        check("R7", {mode, cur_clr, stage_en}, {2'd1, 1'b1, 1'b0});
        cyc(0, 10'd5, 0, 0, 0, 0);
        cyc(0, 10'd5, 0, 0, 0, 1);                   // R7 open
        cyc(0, 10'd5, 0, 0, 0, 0);
        cyc(0, 10'd5, 0, 1, 0, 0);                   // R7 over-temperature
        for (int i = 0; i < 5; i++) cyc(0, 10'd5, 0, 1, 0, 0);   // R8 blocked
        check("R8", {mode, stage_en}, {2'd1, 1'b0});
        cyc(0, 10'd5, 0, 0, 0, 0);                   // R4 after cool down
        cyc(0, 10'd0, 0, 0, 0, 0);                   // R5 idle
        check("R5", {mode, stage_en, load_dflt, cur_clr, stat_clr}, 6'b01_0000);
        cyc(0, 10'h3FF, 0, 0, 0, 0);
        for (int i = 0; i < LIMIT - 1; i++) cyc(1, 10'h3FF, 0, 0, 0, 0);
        check("R2", {mode, stage_en}, {2'd2, 1'b1});  // short run ignored
        cyc(0, 10'h3FF, 0, 0, 0, 0);
        for (int i = 0; i < LIMIT; i++) cyc(1, 10'h3FF, 0, 0, 0, 0);
        check("R2", {mode, stage_en}, {2'd0, 1'b0});
        for (int i = 0; i < 20; i++) cyc(1, 10'h3FF, i[0], 0, 0, 0);  // R6 ignored in shutdown
        check("R6", {mode, load_dflt}, {2'd0, 1'b0});
        cyc(0, 10'd0, 0, 0, 0, 0);                   // R3
        for (int i = 0; i < LIMIT - 1; i++) cyc(1, 10'd0, 0, 0, 0, 0);
        cyc(1, 10'd0, 1, 0, 0, 0);                   // timeout beats soft reset
        check("R6", {mode, load_dflt}, {2'd0, 1'b0});
        cyc(0, 10'd0, 0, 0, 0, 0);

        low_left = 0;
        for (int n = 0; n < 8000; n++) begin
            logic s;
            logic [9:0] c;
            if (low_left > 0) begin s = 1; low_left--; end
            else begin
                s = 0;
                if ($urandom % 40 == 0) low_left = $urandom % 140 + 1;
            end
            c = cur_code;
            if ($urandom % 8 == 0) c = ($urandom % 4 == 0) ? 10'd0 : 10'($urandom);
            cyc(s, c, ($urandom % 32) == 0, ($urandom % 20) == 0,
                ($urandom % 24) == 0, ($urandom % 24) == 0);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule